// File: doc/BRIEF.md
# Flash Operation Status Flag Generator

This block models the read-path status logic of a NOR-style flash bank. It decodes the write-pulse command sequences for byte program, chip erase and sector erase. It also decodes erase suspend and erase resume. While an operation runs, a read returns a status word in place of array data. The top bit of that word is a polarity flag. The bit below it is a toggle flag that inverts on every read access. All other bits read as zero.

The array is a small behavioural byte store. A simulated algorithm timer finishes each operation by pulsing `algo_done`. Each sector has a protect flag. A program aimed at a protected sector changes nothing. An erase that selects only protected sectors also changes nothing. In both cases the bank still shows busy status for a parameterised number of clock cycles, and then returns to reading the array.

All strobes are active low and are sampled on `clk`. A write happens on the clock edge where the write strobe (`ce_n` low with `we_n` low) goes inactive. A read access begins on the clock edge where the read strobe (`ce_n` low with `oe_n` low) first becomes active.

Top module: `flash_status_gen`

## Requirements
- R1: After reset, every byte of the array reads 0xFF and no operation is active. `dout` is zero whenever the read strobe is inactive.
- R2: The program command is four writes: 0xAA, 0x55, 0xA0, then the target address and data. The addresses of the first three writes are ignored. Status reads begin on the cycle after the edge that registers the fourth write.
- R3: On an `algo_done` pulse during a program, the target byte becomes its old value AND the written data. Reads then return array data.
- R4: During a program, `dout[7]` is the inverse of bit 7 of the written data, and `dout[5:0]` is zero.
- R5: While an operation is active, `dout[6]` inverts once per read access. When no operation is active, repeated reads return identical array data.
- R6: Erase is written as 0xAA, 0x55, 0x80, 0xAA, 0x55, followed by a sixth write. A sixth write of 0x10 erases the whole chip. A sixth write of 0x30 erases the sector given by `addr[5:4]`. While the erase is active, `dout[7]` reads 0.
- R7: A sector erase first opens an acceptance window of `TO_CYC` cycles. During the window, `dout[6]` toggles, further 0x30 writes add sectors and restart the window, and `algo_done` is ignored.
- R8: When an erase completes, every selected unprotected sector reads 0xFF. Protected sectors and unselected sectors keep their data.
- R9: A program aimed at a protected sector shows program status for `PROT_PROG_CYC` cycles and ignores `algo_done`. The byte is left unchanged.
- R10: An erase whose selected sectors are all protected shows erase status for `PROT_ERASE_CYC` cycles after the acceptance window. It ignores `algo_done`, changes no data, and then returns to array reads.
- R11: A 0xB0 write during an active erase suspends it. Reads in a selected sector then return `dout[7]`=1 with `dout[6]` held steady. Reads in other sectors return array data. A 0x30 write resumes the erase. Both the suspend write and the resume write invert `dout[6]`.
- R12: While an erase is suspended, a program to an unselected sector runs with toggling status. On `algo_done`, the bank goes back to the suspended state.
- R13: A command sequence that breaks at any step returns the decoder to its first step, and nothing is programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; the top SECT_W bits select the sector |
| din | input | DATA_W | Write data and command byte |
| sect_prot | input | NSECT | Per-sector protect flags |
| algo_done | input | 1 | Completion pulse from the simulated algorithm timer |
| dout | output | DATA_W | Read data: array byte or status word |

## Verification
The checker enforces three rules on every cycle:
- A read access during an active operation flips the toggle flag exactly once. The flag stays steady at all other times, except on a suspend or resume write.
- Accepted program and erase commands put the bank into the matching busy phase on the next cycle.
- The polarity bit seen on `dout` follows the phase: inverted data during a program, and zero during an erase.

Some behaviour cannot be expressed as a per-cycle rule, so only the directed scenarios show it:
- the array contents after completion (AND-programming, masked sector erase);
- the lengths of the protected-operation intervals and the acceptance window;
- sector merging within the window;
- the return from a suspended program to the suspended erase.

// File: rtl/fsf_pkg.sv
package fsf_pkg;

  typedef enum logic [2:0] {
    PH_READ,
    PH_PROG,
    PH_EWIN,
    PH_ERASE,
    PH_SUSP,
    PH_SPROG
  } phase_t;

  localparam logic [7:0] CMD_UNLK_A  = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B  = 8'h55;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_ERSETUP = 8'h80;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECT    = 8'h30;
  localparam logic [7:0] CMD_SUSP    = 8'hB0;

endpackage

// File: rtl/fsf_edge.sv
module fsf_edge #(
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic evt
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  generate
    if (FALLING) begin : g_fall
      assign evt = lvl_q & ~lvl;
    end else begin : g_rise
      assign evt = lvl & ~lvl_q;
    end
  endgenerate
endmodule

// File: rtl/fsf_cmd_seq.sv
module fsf_cmd_seq
  import fsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       erase_en,
  input  logic       wr_evt,
  input  logic [7:0] wbyte,
  output logic       prog_go,
  output logic       chip_go,
  output logic       sect_go,
  output logic       idle
);
  localparam logic [2:0] S_U1 = 3'd0;
  localparam logic [2:0] S_U2 = 3'd1;
  localparam logic [2:0] S_CMD = 3'd2;
  localparam logic [2:0] S_PDATA = 3'd3;
  localparam logic [2:0] S_E1 = 3'd4;
  localparam logic [2:0] S_E2 = 3'd5;
  localparam logic [2:0] S_ECMD = 3'd6;

  logic [2:0] step;

  always_comb begin
    prog_go = en && wr_evt && (step == S_PDATA);
    chip_go = en && wr_evt && (step == S_ECMD) && (wbyte == CMD_CHIP);
    sect_go = en && wr_evt && (step == S_ECMD) && (wbyte == CMD_SECT);
    idle    = (step == S_U1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      step <= S_U1;
    end else if (wr_evt) begin
      unique case (step)
        S_U1:    step <= (wbyte == CMD_UNLK_A) ? S_U2 : S_U1;
        S_U2:    step <= (wbyte == CMD_UNLK_B) ? S_CMD : S_U1;
        S_CMD:   step <= (wbyte == CMD_PROG) ? S_PDATA :
                         ((wbyte == CMD_ERSETUP) && erase_en) ? S_E1 : S_U1;
        S_E1:    step <= (wbyte == CMD_UNLK_A) ? S_E2 : S_U1;
        S_E2:    step <= (wbyte == CMD_UNLK_B) ? S_ECMD : S_U1;
        default: step <= S_U1;
      endcase
    end
  end
endmodule

// File: rtl/fsf_array.sv
module fsf_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SECT_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pg_en,
  input  logic [ADDR_W-1:0]    pg_addr,
  input  logic [DATA_W-1:0]    pg_data,
  input  logic                 er_en,
  input  logic [(1<<SECT_W)-1:0] er_mask,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NSECT = 1 << SECT_W;
  localparam int SDEPTH = DEPTH / NSECT;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (er_en) begin
      for (int i = 0; i < DEPTH; i++)
        if (er_mask[SECT_W'(i / SDEPTH)]) mem[i] <= '1;
    end else if (pg_en) begin
      mem[pg_addr] <= mem[pg_addr] & pg_data;
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import fsf_pkg::*;
#(
  parameter int ADDR_W         = 6,
  parameter int DATA_W         = 8,
  parameter int SECT_W         = 2,
  parameter int PROT_PROG_CYC  = 20,
  parameter int PROT_ERASE_CYC = 60,
  parameter int TO_CYC         = 16,
  localparam int NSECT         = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic [NSECT-1:0]  sect_prot,
  input  logic              algo_done,
  output logic [DATA_W-1:0] dout
);
  localparam int MAXC_A = (PROT_ERASE_CYC > PROT_PROG_CYC) ? PROT_ERASE_CYC : PROT_PROG_CYC;
  localparam int MAXC   = (MAXC_A > TO_CYC) ? MAXC_A : TO_CYC;
  localparam int CNT_W  = $clog2(MAXC + 1);

  function automatic logic [NSECT-1:0] sect_hot(input logic [ADDR_W-1:0] a);
    sect_hot = '0;
    sect_hot[a[ADDR_W-1 -: SECT_W]] = 1'b1;
  endfunction

  function automatic logic [DATA_W-1:0] status_word(input logic pol, input logic tg);
    status_word = '0;
    status_word[DATA_W-1] = pol;
    status_word[DATA_W-2] = tg;
  endfunction

  // strobes and events
  logic wstb, rstb, wr_evt, rd_evt, rd_act;
  assign wstb   = ~ce_n & ~we_n;
  assign rstb   = ~ce_n & ~oe_n;
  assign rd_act = rstb;

  fsf_edge #(.FALLING(1'b1)) u_wr_edge (.clk(clk), .rst_n(rst_n), .lvl(wstb), .evt(wr_evt));
  fsf_edge #(.FALLING(1'b0)) u_rd_edge (.clk(clk), .rst_n(rst_n), .lvl(rstb), .evt(rd_evt));

  // state
  phase_t            ph;
  logic [ADDR_W-1:0] pa;
  logic [DATA_W-1:0] pd;
  logic              pprot;
  logic [NSECT-1:0]  emask;
  logic [CNT_W-1:0]  cnt;
  logic              tog;

  logic [7:0]       wbyte;
  logic [NSECT-1:0] tgt_hot;
  assign wbyte   = din[7:0];
  assign tgt_hot = sect_hot(addr);

  // command decode
  logic seq_en, erase_en, prog_go, chip_go, sect_go, seq_idle;
  assign seq_en   = (ph == PH_READ) || (ph == PH_SUSP);
  assign erase_en = (ph == PH_READ);

  fsf_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(seq_en), .erase_en(erase_en),
    .wr_evt(wr_evt), .wbyte(wbyte),
    .prog_go(prog_go), .chip_go(chip_go), .sect_go(sect_go), .idle(seq_idle)
  );

  // named internal events
  logic prog_phase, erase_act, tog_act, all_prot;
  logic susp_cmd, resume_cmd, add_sect, cmd_flip;
  logic prot_prog_end, prog_done, erase_done, prot_erase_end, win_end;

  always_comb begin
    prog_phase     = (ph == PH_PROG) || (ph == PH_SPROG);
    erase_act      = (ph == PH_EWIN) || (ph == PH_ERASE);
    tog_act        = prog_phase || erase_act;
    all_prot       = ((emask & ~sect_prot) == '0);
    susp_cmd       = wr_evt && (ph == PH_ERASE) && !all_prot && (wbyte == CMD_SUSP);
    resume_cmd     = wr_evt && (ph == PH_SUSP) && seq_idle && (wbyte == CMD_SECT);
    add_sect       = wr_evt && (ph == PH_EWIN) && (wbyte == CMD_SECT);
    cmd_flip       = susp_cmd || resume_cmd;
    prot_prog_end  = prog_phase && pprot && (cnt == CNT_W'(PROT_PROG_CYC - 1));
    prog_done      = prog_phase && !pprot && algo_done;
    erase_done     = (ph == PH_ERASE) && !all_prot && algo_done && !susp_cmd;
    prot_erase_end = (ph == PH_ERASE) && all_prot && (cnt == CNT_W'(PROT_ERASE_CYC - 1));
    win_end        = (ph == PH_EWIN) && !add_sect && (cnt == CNT_W'(TO_CYC - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_READ;
      pa    <= '0;
      pd    <= '0;
      pprot <= 1'b0;
      emask <= '0;
      cnt   <= '0;
      tog   <= 1'b0;
    end else begin
      if ((rd_evt && tog_act) || cmd_flip) tog <= ~tog;
      unique case (ph)
        PH_READ: begin
          cnt <= '0;
          if (prog_go) begin
            pa <= addr; pd <= din; pprot <= |(tgt_hot & sect_prot);
            ph <= PH_PROG;
          end else if (chip_go) begin
            emask <= '1; ph <= PH_ERASE;
          end else if (sect_go) begin
            emask <= tgt_hot; ph <= PH_EWIN;
          end
        end
        PH_PROG, PH_SPROG: begin
          cnt <= cnt + 1'b1;
          if (prot_prog_end || prog_done) ph <= (ph == PH_PROG) ? PH_READ : PH_SUSP;
        end
        PH_EWIN: begin
          if (add_sect) begin
            emask <= emask | tgt_hot; cnt <= '0;
          end else if (win_end) begin
            ph <= PH_ERASE; cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_ERASE: begin
          if (susp_cmd) ph <= PH_SUSP;
          else if (erase_done || prot_erase_end) ph <= PH_READ;
          else cnt <= cnt + 1'b1;
        end
        PH_SUSP: begin
          cnt <= '0;
          if (prog_go) begin
            pa <= addr; pd <= din; pprot <= |(tgt_hot & (sect_prot | emask));
            ph <= PH_SPROG;
          end else if (resume_cmd) begin
            ph <= PH_ERASE;
          end
        end
        default: ph <= PH_READ;
      endcase
    end
  end

  // array
  logic [DATA_W-1:0] arr_q;
  fsf_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .pg_en(prog_done), .pg_addr(pa), .pg_data(pd),
    .er_en(erase_done), .er_mask(emask & ~sect_prot),
    .rd_addr(addr), .rd_data(arr_q)
  );

  // read mux
  logic status_rd, pol;
  always_comb begin
    status_rd = tog_act || ((ph == PH_SUSP) && |(tgt_hot & emask));
    pol       = prog_phase ? ~pd[DATA_W-1] : (ph == PH_SUSP);
    if (!rd_act)        dout = '0;
    else if (status_rd) dout = status_word(pol, tog);
    else                dout = arr_q;
  end
endmodule

// File: rtl/fsf_chk.sv
module fsf_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_evt,
  input logic rd_act,
  input logic tog_act,
  input logic cmd_flip,
  input logic tog,
  input logic prog_go,
  input logic erase_go,
  input logic prog_phase,
  input logic erase_act,
  input logic dout_msb,
  input logic pd_msb
);
  a_r5_tog_per_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && tog_act && !cmd_flip) |=> (tog != $past(tog)));

  a_r5_tog_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rd_evt && tog_act) && !cmd_flip) |=> $stable(tog));

  a_r2_prog_enters_busy: assert property (@(posedge clk) disable iff (!rst_n)
    prog_go |=> prog_phase);

  a_r6_erase_enters_busy: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> erase_act);

  a_r6_erase_pol_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && erase_act) |-> !dout_msb);

  a_r4_prog_pol_inv: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act && prog_phase) |-> (dout_msb != pd_msb));
endmodule

bind flash_status_gen fsf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_evt(rd_evt), .rd_act(rd_act),
  .tog_act(tog_act), .cmd_flip(cmd_flip), .tog(tog),
  .prog_go(prog_go), .erase_go(chip_go || sect_go),
  .prog_phase(prog_phase), .erase_act(erase_act),
  .dout_msb(dout[DATA_W-1]), .pd_msb(pd[DATA_W-1])
);

// File: tb/flash_status_gen_tb.sv
`timescale 1ns/1ps
module flash_status_gen_tb;
  localparam int AW = 6, DW = 8, SW = 2;
  localparam int PPC = 20, PEC = 60, TOC = 16;

  logic clk = 1'b0;
  logic rst_n, ce_n, oe_n, we_n, algo_done;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic [3:0] sect_prot;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_status_gen #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW),
    .PROT_PROG_CYC(PPC), .PROT_ERASE_CYC(PEC), .TO_CYC(TOC)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .sect_prot(sect_prot), .algo_done(algo_done), .dout(dout));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); v = dout; ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pulse_done();
    @(negedge clk); algo_done = 1'b1;
    @(negedge clk); algo_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    wr(6'd21, 8'hAA); wr(6'd42, 8'h55); wr(6'd3, 8'hA0); wr(a, d);
  endtask

  task automatic erase_pre();
    wr(6'd0, 8'hAA); wr(6'd1, 8'h55); wr(6'd2, 8'h80); wr(6'd3, 8'hAA); wr(6'd4, 8'h55);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk); chk("R1 idle output zero", dout, 8'h00);
    rd(6'd0, v);  chk("R1 erased at reset addr0", v, 8'hFF);
    rd(6'd63, v); chk("R1 erased at reset addr63", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v1, v2;
    prog(6'd5, 8'h3C);
    rd(6'd5, v1); chk("R4 prog status inverse bit7", v1 & 8'hBF, 8'h80);
    rd(6'd9, v2); chk("R5 toggle per read", {7'b0, v2[6]}, {7'b0, ~v1[6]});
    pulse_done();
    rd(6'd5, v1); chk("R3 programmed byte", v1, 8'h3C);
    prog(6'd5, 8'hF0); pulse_done();
    rd(6'd5, v1); chk("R3 program ANDs old data", v1, 8'h30);
    rd(6'd5, v2); chk("R5 no toggle when idle", v2, 8'h30);
    prog(6'd6, 8'h81);
    rd(6'd6, v1); chk("R4 prog status bit7 zero for set bit", v1 & 8'hBF, 8'h00);
    pulse_done();
    rd(6'd6, v1); chk("R3 second byte", v1, 8'h81);
  endtask

  task automatic t_bad_seq();
    logic [7:0] v;
    wr(6'd0, 8'hAA); wr(6'd0, 8'h12); wr(6'd0, 8'hA0); wr(6'd7, 8'h00);
    rd(6'd7, v); chk("R13 broken sequence no status", v, 8'hFF);
    pulse_done();
    rd(6'd7, v); chk("R13 broken sequence no program", v, 8'hFF);
  endtask

  task automatic t_prot_prog();
    logic [7:0] v;
    sect_prot = 4'b0010;
    prog(6'd20, 8'h00);
    rd(6'd20, v); chk("R9 protected program shows status", v & 8'hBF, 8'h80);
    pulse_done();
    rd(6'd20, v); chk("R9 done ignored while protected", v & 8'hBF, 8'h80);
    idle(PPC);
    rd(6'd20, v); chk("R9 protected byte unchanged", v, 8'hFF);
    sect_prot = 4'b0000;
  endtask

  task automatic t_sector_erase();
    logic [7:0] v1, v2;
    prog(6'd33, 8'h12); pulse_done();
    prog(6'd49, 8'h34); pulse_done();
    prog(6'd17, 8'h55); pulse_done();
    erase_pre(); wr(6'd32, 8'h30);
    rd(6'd33, v1); chk("R6 erase status bit7 low", v1 & 8'hBF, 8'h00);
    rd(6'd33, v2); chk("R7 toggle in window", {7'b0, v2[6]}, {7'b0, ~v1[6]});
    wr(6'd48, 8'h30);
    pulse_done();
    rd(6'd49, v1); chk("R7 done ignored in window", v1 & 8'hBF, 8'h00);
    idle(TOC + 4);
    rd(6'd33, v1); chk("R7 still erasing after window", v1 & 8'hBF, 8'h00);
    pulse_done();
    rd(6'd33, v1); chk("R8 first sector erased", v1, 8'hFF);
    rd(6'd49, v1); chk("R7 added sector erased", v1, 8'hFF);
    rd(6'd17, v1); chk("R8 unselected sector kept", v1, 8'h55);
    rd(6'd5, v1);  chk("R8 unselected sector 0 kept", v1, 8'h30);
  endtask

  task automatic t_prot_erase();
    logic [7:0] v;
    sect_prot = 4'b0010;
    erase_pre(); wr(6'd0, 8'h10);
    rd(6'd5, v); chk("R6 chip erase status", v & 8'hBF, 8'h00);
    pulse_done();
    rd(6'd17, v); chk("R8 protected sector survives chip erase", v, 8'h55);
    rd(6'd5, v);  chk("R8 chip erase clears sector 0", v, 8'hFF);
    erase_pre(); wr(6'd16, 8'h30);
    rd(6'd17, v); chk("R10 all-protected erase status", v & 8'hBF, 8'h00);
    pulse_done();
    idle(TOC + 10);
    rd(6'd17, v); chk("R10 still busy before interval ends", v & 8'hBF, 8'h00);
    idle(PEC);
    rd(6'd17, v); chk("R10 data unchanged and read mode", v, 8'h55);
    sect_prot = 4'b0000;
  endtask

  task automatic t_suspend();
    logic [7:0] v1, v2, v3;
    prog(6'd40, 8'h0F); pulse_done();
    erase_pre(); wr(6'd40, 8'h30);
    idle(TOC + 2);
    rd(6'd40, v1); chk("R6 erasing before suspend", v1 & 8'hBF, 8'h00);
    wr(6'd0, 8'hB0);
    rd(6'd40, v2); chk("R11 suspended bit7 high", v2 & 8'hBF, 8'h80);
    chk("R11 suspend write flips toggle", {7'b0, v2[6]}, {7'b0, ~v1[6]});
    rd(6'd40, v3); chk("R11 toggle steady in suspend", v3, v2);
    rd(6'd17, v3); chk("R11 other sector reads array", v3, 8'h55);
    prog(6'd6, 8'hA5);
    rd(6'd6, v1); chk("R12 suspend-program status", v1 & 8'hBF, 8'h00);
    rd(6'd6, v3); chk("R12 suspend-program toggles", {7'b0, v3[6]}, {7'b0, ~v1[6]});
    pulse_done();
    rd(6'd6, v1);  chk("R12 suspend-program data", v1, 8'hA5);
    rd(6'd40, v1); chk("R12 back to suspended", v1 & 8'hBF, 8'h80);
    wr(6'd0, 8'h30);
    rd(6'd40, v2); chk("R11 resumed erase status", v2 & 8'hBF, 8'h00);
    pulse_done();
    rd(6'd40, v1); chk("R11 resumed erase completes", v1, 8'hFF);
    rd(6'd6, v1);  chk("R8 other sector kept after resume", v1, 8'hA5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; din = '0; sect_prot = '0; algo_done = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_program();
    t_bad_seq();
    t_prot_prog();
    t_sector_erase();
    t_prot_erase();
    t_suspend();
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule